// File: doc/BRIEF.md
# Per-Phase Boost Pulse Timer

This block makes the short overdrive enables for a two-phase unipolar stepper drive. A sequencer upstream presents the drive code of each phase. Whenever the code of one phase changes, that phase's one-shot starts. The one-shot holds its boost enable high for a programmed number of clock cycles, and during that time the power stage connects the winding to the higher supply so that the current rises quickly. A clock-cycle counter replaces the usual resistor-capacitor time constant.

The two phases have separate one-shots that share one duration setting. A common hold input can freeze both counters to stretch the pulse, as an external circuit would by clamping the timing node. A second setting caps the pulse, so a stuck hold can never leave the boost on without limit. An inhibit input clears both one-shots and forces both enables low.

Top module: `boost_pulse_timer`

## Requirements
- R1: After reset both boost outputs are low, and a drive code equal to all zeros does not start a pulse.
- R2: When the value of `phase_a_i` sampled at a rising edge differs from the value sampled at the previous edge, `boost_a_o` is high from that edge for exactly `dur_cfg_i` cycles, provided that hold stays low and `max_cfg_i` is at least that long.
- R3: The two phases are independent. A change on `phase_b_i` drives only `boost_b_o` and a change on `phase_a_i` drives only `boost_a_o`. Both phases use the same `dur_cfg_i`.
- R4: A change of a phase's code while its pulse is active restarts that pulse with the full `dur_cfg_i` count.
- R5: When `dur_cfg_i` is zero, a change of the code starts no pulse.
- R6: While `hold_i` is high, the remaining count of an active pulse does not decrease. Each held cycle lengthens the pulse by one cycle.
- R7: A pulse never lasts more than `max_cfg_i` cycles (with `max_cfg_i` of 1 or more) after its last trigger, even if hold stays high.
- R8: While `inhibit_i` is high, both boost outputs are low. At each edge inside an inhibit interval, the active pulses are cleared and code changes start nothing. A pulse that was cleared does not come back when inhibit is released.
- R9: When the codes stay unchanged, no new pulse starts, and every pulse ends after its count has run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inhibit_i | input | 1 | High turns off all boost and clears the one-shots |
| hold_i | input | 1 | High freezes the remaining count of active pulses |
| dur_cfg_i | input | CNT_W | Pulse duration in cycles. Zero disables boosting |
| max_cfg_i | input | CNT_W | Hard maximum pulse length in cycles |
| phase_a_i | input | PH_W | Drive code of phase A from the sequencer |
| phase_b_i | input | PH_W | Drive code of phase B from the sequencer |
| boost_a_o | output | 1 | Boost enable for phase A |
| boost_b_o | output | 1 | Boost enable for phase B |

## Verification
The embedded properties check on every cycle that a trigger loads the full duration, that an unheld pulse counts down by one, that a held pulse keeps its count, that an active pulse never reaches the cap, that a zero duration keeps the timer idle, and that no enable is high on the first cycle after inhibit is released. Only the bench scenarios can show the complete pulse lengths: the exact cycle count, a restart that adds to the cycles already spent, a stretch by hold, truncation at the cap, and a cleared pulse that stays off after inhibit ends.

// File: rtl/boost_pkg.sv
package boost_pkg;
  // Action the one-shot takes at the next clock edge
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_LOAD,
    ACT_COUNT,
    ACT_HOLD,
    ACT_END,
    ACT_CLEAR
  } os_act_e;

  localparam int unsigned BOOST_PH_W  = 2;
  localparam int unsigned BOOST_CNT_W = 16;
endpackage

// File: rtl/boost_chg_det.sv
module boost_chg_det #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] state_i,
  output logic         chg_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= state_i;
  end

  assign chg_o = (state_i != prev_q);
endmodule

// File: rtl/boost_oneshot.sv
module boost_oneshot
  import boost_pkg::*;
#(
  parameter int unsigned CNT_W = BOOST_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inhibit_i,
  input  logic             trig_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] dur_i,
  input  logic [CNT_W-1:0] max_i,
  output logic             boost_o
);
  logic [CNT_W-1:0] remain_q, remain_d;
  logic [CNT_W-1:0] elapsed_q, elapsed_d;
  logic [CNT_W:0]   elapsed_inc;
  logic             active;
  logic             en;
  os_act_e          act;

  assign active      = (remain_q != '0);
  assign elapsed_inc = {1'b0, elapsed_q} + 1'b1;

  always_comb begin
    if (inhibit_i)                    act = ACT_CLEAR;
    else if (trig_i && dur_i != '0)   act = ACT_LOAD;
    else if (!active)                 act = ACT_IDLE;
    else if (elapsed_inc >= {1'b0, max_i}) act = ACT_END;
    else if (hold_i)                  act = ACT_HOLD;
    else                              act = ACT_COUNT;
  end

  always_comb begin
    remain_d  = remain_q;
    elapsed_d = elapsed_q;
    unique case (act)
      ACT_CLEAR, ACT_END: begin
        remain_d  = '0;
        elapsed_d = '0;
      end
      ACT_LOAD: begin
        remain_d  = dur_i;
        elapsed_d = '0;
      end
      ACT_HOLD:  elapsed_d = elapsed_inc[CNT_W-1:0];
      ACT_COUNT: begin
        remain_d  = remain_q - 1'b1;
        elapsed_d = elapsed_inc[CNT_W-1:0];
      end
      default: ;
    endcase
  end

  assign en = (act != ACT_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q  <= '0;
      elapsed_q <= '0;
    end else if (en) begin
      remain_q  <= remain_d;
      elapsed_q <= elapsed_d;
    end
  end

  assign boost_o = active && !inhibit_i;

  // R8
  inhibit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |=> (remain_q == '0));

  // R4
  trigger_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !inhibit_i && dur_i != '0) |=> (remain_q == $past(dur_i)));

  // R2
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !trig_i && !inhibit_i && !hold_i)
      |=> (remain_q == $past(remain_q) - 1'b1 || remain_q == '0));

  // R6
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !trig_i && !inhibit_i && hold_i)
      |=> (remain_q == $past(remain_q) || remain_q == '0));

  // R7
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && max_i != '0 && $stable(max_i)) |-> (elapsed_q < max_i));

  // R5
  zero_dur_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dur_i == '0 && !active) |=> !active);
endmodule

// File: rtl/boost_pulse_timer.sv
module boost_pulse_timer
  import boost_pkg::*;
#(
  parameter int unsigned PH_W  = BOOST_PH_W,
  parameter int unsigned CNT_W = BOOST_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inhibit_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] dur_cfg_i,
  input  logic [CNT_W-1:0] max_cfg_i,
  input  logic [PH_W-1:0]  phase_a_i,
  input  logic [PH_W-1:0]  phase_b_i,
  output logic             boost_a_o,
  output logic             boost_b_o
);
  localparam int unsigned N_PH = 2;

  logic [PH_W-1:0] code   [N_PH];
  logic [N_PH-1:0] chg;
  logic [N_PH-1:0] boost;

  assign code[0] = phase_a_i;
  assign code[1] = phase_b_i;

  for (genvar p = 0; p < N_PH; p++) begin : g_phase
    boost_chg_det #(.W(PH_W)) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_i (code[p]),
      .chg_o   (chg[p])
    );

    boost_oneshot #(.CNT_W(CNT_W)) u_os (
      .clk       (clk),
      .rst_n     (rst_n),
      .inhibit_i (inhibit_i),
      .trig_i    (chg[p]),
      .hold_i    (hold_i),
      .dur_i     (dur_cfg_i),
      .max_i     (max_cfg_i),
      .boost_o   (boost[p])
    );
  end

  assign boost_a_o = boost[0];
  assign boost_b_o = boost[1];

  // R8
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inhibit_i) |-> (!boost_a_o && !boost_b_o));
endmodule

// File: tb/boost_pulse_timer_bench.sv
module boost_pulse_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 2;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          inh, hold;
  logic [CW-1:0] dur, maxc;
  logic [PW-1:0] pa, pb;
  logic          boost_a_o, boost_b_o;

  int n_cmp = 0;
  int n_bad = 0;
  int ca, cb;
  string tag;
  bit done = 0;

  // reference state per phase
  logic [PW-1:0] m_prev [2];
  int m_cnt [2];
  int m_age [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  boost_pulse_timer #(.PH_W(PW), .CNT_W(CW)) u_boost_pulse_timer (
    .clk(clk), .rst_n(rst_n), .inhibit_i(inh), .hold_i(hold),
    .dur_cfg_i(dur), .max_cfg_i(maxc), .phase_a_i(pa), .phase_b_i(pb),
    .boost_a_o(boost_a_o), .boost_b_o(boost_b_o));

  function automatic bit exp_boost(int p);
    return (m_cnt[p] != 0) && !inh;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < 2; p++) begin
      m_prev[p] = '0; m_cnt[p] = 0; m_age[p] = 0;
    end
  endtask

  task automatic model_step();
    for (int p = 0; p < 2; p++) begin
      logic [PW-1:0] cur;
      bit chg;
      cur = (p == 0) ? pa : pb;
      chg = (cur != m_prev[p]);
      m_prev[p] = cur;
      if (inh) begin
        m_cnt[p] = 0; m_age[p] = 0;
      end else if (chg && dur != 0) begin
        m_cnt[p] = int'(dur); m_age[p] = 0;
      end else if (m_cnt[p] != 0) begin
        if (m_age[p] + 1 >= int'(maxc)) begin
          m_cnt[p] = 0; m_age[p] = 0;
        end else if (hold) m_age[p]++;
        else begin
          m_cnt[p]--; m_age[p]++;
        end
      end
    end
  endtask

  task automatic chk_bit(logic act, logic exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk_bit(boost_a_o, exp_boost(0), "boost_a");
    chk_bit(boost_b_o, exp_boost(1), "boost_b");
    ca += int'(boost_a_o);
    cb += int'(boost_b_o);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; inh = 0; hold = 0; dur = 16'd6; maxc = 16'd100; pa = '0; pb = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and no trigger from a zero code
    tag = "R1";
    chk_bit(boost_a_o, 1'b0, "reset a");
    chk_bit(boost_b_o, 1'b0, "reset b");
    ticks(3);

    // R2 exact length; R3 phase B unaffected
    tag = "R2"; ca = 0; cb = 0;
    pa = 2'b01; ticks(12);
    chk_int(ca, 6, "pulse length a");
    tag = "R3"; chk_int(cb, 0, "b idle while a fires");

    // R3 both phases share the duration
    ca = 0; cb = 0;
    pa = 2'b11; pb = 2'b10; ticks(12);
    chk_int(ca, 6, "length a");
    chk_int(cb, 6, "length b");

    // R4 restart during an active pulse
    tag = "R4"; ca = 0; cb = 0;
    pa = 2'b10; ticks(3);
    pa = 2'b00; ticks(12);
    chk_int(ca, 9, "restarted length");

    // R5 zero duration disables
    tag = "R5"; ca = 0; cb = 0; dur = 0;
    pa = 2'b01; pb = 2'b01; ticks(8);
    chk_int(ca + cb, 0, "no pulse");

    // R6 hold stretches
    tag = "R6"; dur = 4; ca = 0; cb = 0;
    pa = 2'b11; tick();
    hold = 1; ticks(5);
    hold = 0; ticks(8);
    chk_int(ca, 9, "stretched length");

    // R7 cap under permanent hold
    tag = "R7"; maxc = 7; ca = 0; cb = 0;
    hold = 1; pb = 2'b00; ticks(14);
    chk_int(cb, 7, "capped length");
    hold = 0; maxc = 100;

    // R8 inhibit clears and blocks triggers
    tag = "R8"; dur = 8;
    pa = 2'b10; ticks(2);
    ca = 0; cb = 0;
    inh = 1; tick();
    pa = 2'b01; ticks(2);
    inh = 0; ticks(10);
    chk_int(ca, 0, "no boost after inhibit");

    // R9 steady codes keep boost low
    tag = "R9"; ca = 0; cb = 0;
    ticks(20);
    chk_int(ca + cb, 0, "quiet on steady codes");

    // R2 constrained random, every cycle compared with the model
    tag = "R2 random";
    for (int seg = 0; seg < 20; seg++) begin
      dur  = 16'($urandom_range(0, 12));
      maxc = 16'($urandom_range(1, 20));
      for (int c = 0; c < 60; c++) begin
        if ($urandom_range(0, 3) == 0) pa = 2'($urandom);
        if ($urandom_range(0, 3) == 0) pb = 2'($urandom);
        hold = ($urandom_range(0, 4) == 0);
        inh  = ($urandom_range(0, 19) == 0);
        tick();
      end
    end
    inh = 0; hold = 0;
    ticks(25);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule